// File: doc/BRIEF.md
# Receive Byte Holding and Interrupt Combiner

This block sits between a serial receiver's deserialiser and the host side of a UART. It keeps the last received byte in a one-deep holding register, tracks whether that byte has been consumed, and records overrun, framing and parity status. When a new byte arrives before the host has read the previous one, the old byte is lost: the new one replaces it and the overrun flag marks the loss.

It also watches two modem status inputs, data-set-ready and clear-to-send. Each is delivered as a level together with an update strobe. An update that moves a line away from its latched level raises a shared modem-change flag. An update that leaves both lines where they were lowers that flag. A timer-elapsed pulse from an external counter sets a timer flag. A single interrupt line combines four sources, each gated by its own enable bit: the byte-held flag, the transmit-buffer-empty input, the modem-change flag and the timer flag.

Top module: `rx_event_irq`

## Requirements
- R1: After reset the holding register reads zero. The byte-held, overrun, framing, parity, modem-change and timer flags and both latched modem levels are 0. All four interrupt enables are cleared, so `irq` stays low even while `tx_empty` is high.
- R2: A cycle with `rx_valid` high writes `rx_data` into the holding register on that clock edge, whether or not a byte is already held.
- R3: A byte that arrives while no byte is held sets the byte-held flag and clears the overrun flag on the next edge.
- R4: A byte that arrives while a byte is held, with no host read in the same cycle, sets the overrun flag. The held byte is replaced by the new one.
- R5: A host read (`host_rd`) clears the byte-held and overrun flags on the next edge. If a byte arrives in the same cycle, the read counts first: the byte-held flag ends at 1, the overrun flag at 0, and the register holds the new byte.
- R6: Every arriving byte clears the framing and parity flags. A framing or parity report strobe sets its flag, and wins over a byte arriving in the same cycle.
- R7: A modem-line update whose level differs from the latched level for that line sets the modem-change flag and latches the new level. A cycle with one or more updates and no change on any line clears the flag.
- R8: The flag-clear strobe clears the modem-change and timer flags. A set condition in the same cycle wins.
- R9: A timer-elapsed pulse sets the timer flag on the next edge.
- R10: `en_wr` loads the four enables from `en_val`: bit 0 byte held, bit 1 transmit empty, bit 2 modem change, bit 3 timer. `irq` is high exactly when at least one source is active and its enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received-byte strobe |
| rx_data | input | DW | Received byte |
| frame_err_in | input | 1 | Framing error report strobe |
| par_err_in | input | 1 | Parity error report strobe |
| host_rd | input | 1 | Host read of the holding register |
| dsr_upd | input | 1 | Data-set-ready update strobe |
| dsr_lvl | input | 1 | Data-set-ready level |
| cts_upd | input | 1 | Clear-to-send update strobe |
| cts_lvl | input | 1 | Clear-to-send level |
| tmr_pulse | input | 1 | Timer elapsed pulse |
| tx_empty | input | 1 | Transmit buffer empty level |
| flag_clr | input | 1 | Clears modem-change and timer flags |
| en_wr | input | 1 | Interrupt enable write strobe |
| en_val | input | 4 | Enable bits: 0 rx held, 1 tx empty, 2 modem change, 3 timer |
| rx_buf | output | DW | Holding register contents |
| rx_held | output | 1 | Byte-held flag |
| rx_overrun | output | 1 | Overrun flag |
| frame_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |
| ds_change | output | 1 | Modem-change flag |
| tmr_flag | output | 1 | Timer elapsed flag |
| dsr_q | output | 1 | Latched data-set-ready level |
| cts_q | output | 1 | Latched clear-to-send level |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions. One is a host read landing in the same cycle as a new byte, where the read must count first. Another is a modem-line change landing on a flag-clear strobe. The bench first fills the holding register, then raises both strobes on the same edge and checks the flags afterwards. The modem test also sends one update that changes a line and another that does not, in the same cycle, to confirm that a change on either line keeps the flag set.

// File: rtl/rx_event_irq.sv
module rx_event_irq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          frame_err_in,
  input  logic          par_err_in,
  input  logic          host_rd,
  input  logic          dsr_upd,
  input  logic          dsr_lvl,
  input  logic          cts_upd,
  input  logic          cts_lvl,
  input  logic          tmr_pulse,
  input  logic          tx_empty,
  input  logic          flag_clr,
  input  logic          en_wr,
  input  logic [3:0]    en_val,
  output logic [DW-1:0] rx_buf,
  output logic          rx_held,
  output logic          rx_overrun,
  output logic          frame_err,
  output logic          par_err,
  output logic          ds_change,
  output logic          tmr_flag,
  output logic          dsr_q,
  output logic          cts_q,
  output logic          irq
);

  logic [3:0] irq_en;
  logic       line_moved;
  logic       line_touched;

  assign line_moved   = (dsr_upd && (dsr_lvl != dsr_q)) || (cts_upd && (cts_lvl != cts_q));
  assign line_touched = dsr_upd || cts_upd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_buf     <= '0;
      rx_held    <= 1'b0;
      rx_overrun <= 1'b0;
      frame_err  <= 1'b0;
      par_err    <= 1'b0;
    end else begin
      if (rx_valid) begin
        rx_buf     <= rx_data;
        rx_held    <= 1'b1;
        rx_overrun <= rx_held && !host_rd;
      end else if (host_rd) begin
        rx_held    <= 1'b0;
        rx_overrun <= 1'b0;
      end
      if (frame_err_in)  frame_err <= 1'b1;
      else if (rx_valid) frame_err <= 1'b0;
      if (par_err_in)    par_err   <= 1'b1;
      else if (rx_valid) par_err   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsr_q     <= 1'b0;
      cts_q     <= 1'b0;
      ds_change <= 1'b0;
      tmr_flag  <= 1'b0;
      irq_en    <= 4'b0;
    end else begin
      if (dsr_upd) dsr_q <= dsr_lvl;
      if (cts_upd) cts_q <= cts_lvl;
      if (line_moved)                    ds_change <= 1'b1;
      else if (line_touched || flag_clr) ds_change <= 1'b0;
      if (tmr_pulse)     tmr_flag <= 1'b1;
      else if (flag_clr) tmr_flag <= 1'b0;
      if (en_wr) irq_en <= en_val;
    end
  end

  assign irq = |(irq_en & {tmr_flag, ds_change, tx_empty, rx_held});

  p_buf_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_buf == $past(rx_data));
  p_empty_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_held) |=> (rx_held && !rx_overrun));
  p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_held && !host_rd) |=> rx_overrun);
  p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !rx_valid) |=> (!rx_held && !rx_overrun));
  p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !frame_err_in && !par_err_in) |=> (!frame_err && !par_err));
  p_line_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dsr_upd && (dsr_lvl != dsr_q)) |=> ds_change);
  p_timer_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_pulse |=> tmr_flag);
  p_no_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_held && !tx_empty && !ds_change && !tmr_flag) |-> !irq);

endmodule

// File: tb/tb_rx_event_irq.sv
module tb_rx_event_irq;
  localparam int DW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, frame_err_in = 0, par_err_in = 0, host_rd = 0;
  logic [DW-1:0] rx_data = '0;
  logic dsr_upd = 0, dsr_lvl = 0, cts_upd = 0, cts_lvl = 0;
  logic tmr_pulse = 0, tx_empty = 0, flag_clr = 0, en_wr = 0;
  logic [3:0] en_val = '0;
  logic [DW-1:0] rx_buf;
  logic rx_held, rx_overrun, frame_err, par_err, ds_change, tmr_flag, dsr_q, cts_q, irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_event_irq #(.DW(DW)) dut (.*);

  task automatic step();
    @(posedge clk); #1;
    rx_valid = 0; frame_err_in = 0; par_err_in = 0; host_rd = 0;
    dsr_upd = 0; cts_upd = 0; tmr_pulse = 0; flag_clr = 0; en_wr = 0;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    tx_empty = 1; #1;
    chk("R1", "buf", rx_buf, 0);
    chk("R1", "flags", {rx_held, rx_overrun, frame_err, par_err, ds_change, tmr_flag, dsr_q, cts_q}, 0);
    chk("R1", "irq with enables cleared", irq, 0);
    tx_empty = 0;
  endtask

  task automatic t_load_empty();
    rx_valid = 1; rx_data = 8'h3C; step();
    chk("R2", "buf", rx_buf, 8'h3C);
    chk("R3", "held/overrun", {rx_held, rx_overrun}, 2'b10);
  endtask

  task automatic t_overrun();
    rx_valid = 1; rx_data = 8'hA5; step();
    chk("R4", "buf overwritten", rx_buf, 8'hA5);
    chk("R4", "held/overrun", {rx_held, rx_overrun}, 2'b11);
  endtask

  task automatic t_read();
    host_rd = 1; step();
    chk("R5", "held/overrun after read", {rx_held, rx_overrun}, 2'b00);
    chk("R5", "buf kept", rx_buf, 8'hA5);
    rx_valid = 1; rx_data = 8'h11; step();
    chk("R3", "reload after read", {rx_held, rx_overrun}, 2'b10);
    host_rd = 1; rx_valid = 1; rx_data = 8'h22; step();
    chk("R5", "read+byte held/overrun", {rx_held, rx_overrun}, 2'b10);
    chk("R5", "read+byte buf", rx_buf, 8'h22);
  endtask

  task automatic t_errors();
    frame_err_in = 1; par_err_in = 1; step();
    chk("R6", "errors set", {frame_err, par_err}, 2'b11);
    step();
    chk("R6", "errors hold", {frame_err, par_err}, 2'b11);
    rx_valid = 1; rx_data = 8'h5A; step();
    chk("R6", "byte clears errors", {frame_err, par_err}, 2'b00);
    rx_valid = 1; rx_data = 8'h5B; par_err_in = 1; step();
    chk("R6", "report wins over byte", {frame_err, par_err}, 2'b01);
    host_rd = 1; step();
  endtask

  task automatic t_modem();
    dsr_upd = 1; dsr_lvl = 1; step();
    chk("R7", "dsr change", {ds_change, dsr_q}, 2'b11);
    dsr_upd = 1; dsr_lvl = 1; step();
    chk("R7", "no-change update clears", ds_change, 0);
    dsr_upd = 1; dsr_lvl = 1; cts_upd = 1; cts_lvl = 1; step();
    chk("R7", "cts change with idle dsr", {ds_change, cts_q}, 2'b11);
    step();
    chk("R7", "flag holds without update", ds_change, 1);
    flag_clr = 1; step();
    chk("R8", "clear strobe", ds_change, 0);
    cts_upd = 1; cts_lvl = 0; flag_clr = 1; step();
    chk("R8", "change wins over clear", {ds_change, cts_q}, 2'b10);
    flag_clr = 1; step();
  endtask

  task automatic t_timer();
    tmr_pulse = 1; step();
    chk("R9", "timer set", tmr_flag, 1);
    tmr_pulse = 1; flag_clr = 1; step();
    chk("R8", "timer set wins", tmr_flag, 1);
    flag_clr = 1; step();
    chk("R8", "timer cleared", tmr_flag, 0);
  endtask

  task automatic t_irq();
    chk("R10", "held before irq test", rx_held, 0);
    en_wr = 1; en_val = 4'b1111; step();
    chk("R10", "idle irq", irq, 0);
    tx_empty = 1; #1;
    chk("R10", "tx empty bit1", irq, 1);
    en_wr = 1; en_val = 4'b1101; step();
    chk("R10", "tx empty masked", irq, 0);
    tx_empty = 0;
    rx_valid = 1; rx_data = 8'h01; step();
    chk("R10", "held bit0", irq, 1);
    en_wr = 1; en_val = 4'b1000; step();
    chk("R10", "held masked", irq, 0);
    tmr_pulse = 1; step();
    chk("R10", "timer bit3", irq, 1);
    flag_clr = 1; en_wr = 1; en_val = 4'b0100; step();
    chk("R10", "timer cleared, dsc enabled", irq, 0);
    dsr_upd = 1; dsr_lvl = 0; step();
    chk("R10", "dsc bit2", irq, 1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_load_empty();
    t_overrun();
    t_read();
    t_errors();
    t_modem();
    t_timer();
    t_irq();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule